// File: doc/BRIEF.md
# Shared-Resource Quadratic Evaluator

This block evaluates y = A·x² + B·x + C for unsigned operands using exactly one multiplier and one adder. A small controller steps both units through a fixed schedule. Operand multiplexers pick what each unit sees in each step, and intermediate registers hold x, x² and Bx+C between steps. The multiplier output always feeds the adder's first input. The adder's second input is either C or the held Bx+C.

A request is accepted by raising `go` while `ready` is high. `x_in` is captured when the request is accepted. `a_in`, `b_in` and `c_in` are read directly by the datapath, so the requester holds them steady until `done`. The result is exact: the internal width is 3·W+2 bits. Requests are not overlapped. A new one can be accepted in the cycle that `done` is shown, which gives one result every five cycles.

Top module: `quad_fsmd`

## Requirements
- R1: After a synchronous reset, `y_out` is 0, `done` is 0 and `ready` is 1.
- R2: Each result on `y_out` equals A·x² + B·x + C computed exactly as unsigned integers. This holds for all-zero operands and for all operands at their maximum value of 2^W−1.
- R3: `done` is high for exactly one cycle. It rises on the fourth rising clock edge after the edge that samples `go` high with `ready` high, and `y_out` takes the new result on that same edge.
- R4: `ready` is low in the four cycles between acceptance and `done`, and is high again in the cycle where `done` is high.
- R5: `go` raised while `ready` is low is ignored: the running result is unchanged and no extra `done` follows.
- R6: x is captured at acceptance; changes on `x_in` afterwards do not affect the result.
- R7: `y_out` keeps its value in every cycle in which `done` is low.
- R8: With `go` held high and new operands presented in each `done` cycle, a result is produced every five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Request start; sampled only while ready |
| x_in | input | W | Variable x, captured at acceptance |
| a_in | input | W | Coefficient A, held until done |
| b_in | input | W | Coefficient B, held until done |
| c_in | input | W | Constant C, held until done |
| y_out | output | 3·W+2 | Registered result |
| done | output | 1 | One-cycle pulse when y_out is updated |
| ready | output | 1 | High when a request can be accepted |

## Verification
A wrong step in the controller has two visible effects. It moves the `done` pulse away from its fixed distance of four edges after acceptance, and it changes the length of the `ready` low window. Both show up within five cycles of a request. A wrong operand selection or a wrong register load shows up only in the value of `y_out` at `done`. Because of this, the operand sets are chosen so that each of A, B, C and x adds a distinct amount to the result, and the all-ones set tests carry propagation through the full width. Keeping `go` raised during a run and changing `x_in` after acceptance would expose a controller that restarts or a datapath that reads x without capturing it. Each of these shows up either as a second `done` or as a wrong value at the first `done`.

// File: rtl/quad_fsmd_pkg.sv
package quad_fsmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SQ   = 3'd1,
    ST_BXC  = 3'd2,
    ST_AX2  = 3'd3,
    ST_SUM  = 3'd4
  } step_t;

  typedef enum logic {
    MA_X  = 1'b0,
    MA_XX = 1'b1
  } ma_sel_t;

  typedef enum logic [1:0] {
    MB_X = 2'd0,
    MB_A = 2'd1,
    MB_B = 2'd2
  } mb_sel_t;

  typedef enum logic {
    AB_C   = 1'b0,
    AB_BXC = 1'b1
  } ab_sel_t;

  typedef struct packed {
    logic    ld_x;
    logic    ld_xx;
    logic    ld_bxc;
    logic    ld_y;
    ma_sel_t ma;
    mb_sel_t mb;
    ab_sel_t ab;
  } ctrl_t;

endpackage

// File: rtl/quad_ldreg.sv
module quad_ldreg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/quad_ctrl.sv
module quad_ctrl
  import quad_fsmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  go,
  output ctrl_t ctl,
  output logic  idle
);
  step_t st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    unique case (st_q)
      ST_IDLE: begin
        ctl.ld_x = go;
        if (go) st_d = ST_SQ;
      end
      ST_SQ: begin
        ctl.ma    = MA_X;
        ctl.mb    = MB_X;
        ctl.ld_xx = 1'b1;
        st_d      = ST_BXC;
      end
      ST_BXC: begin
        ctl.ma     = MA_X;
        ctl.mb     = MB_B;
        ctl.ab     = AB_C;
        ctl.ld_bxc = 1'b1;
        st_d       = ST_AX2;
      end
      ST_AX2: begin
        ctl.ma = MA_XX;
        ctl.mb = MB_A;
        ctl.ab = AB_BXC;
        st_d   = ST_SUM;
      end
      ST_SUM: begin
        ctl.ma   = MA_XX;
        ctl.mb   = MB_A;
        ctl.ab   = AB_BXC;
        ctl.ld_y = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign idle = (st_q == ST_IDLE);
endmodule

// File: rtl/quad_dpath.sv
module quad_dpath
  import quad_fsmd_pkg::*;
#(
  parameter int W  = 8,
  parameter int RW = 3 * W + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctl,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [W-1:0]  c_in,
  output logic [RW-1:0] y
);
  localparam int PAD = RW - W;

  logic [W-1:0]  x_q;
  logic [RW-1:0] xx_q, bxc_q;
  logic [RW-1:0] mul_a, mul_b, prod, add_b, sum;

  quad_ldreg #(.N(W))  u_xreg   (.clk(clk), .rst(rst), .ld(ctl.ld_x),   .d(x_in), .q(x_q));
  quad_ldreg #(.N(RW)) u_xxreg  (.clk(clk), .rst(rst), .ld(ctl.ld_xx),  .d(prod), .q(xx_q));
  quad_ldreg #(.N(RW)) u_bxcreg (.clk(clk), .rst(rst), .ld(ctl.ld_bxc), .d(sum),  .q(bxc_q));
  quad_ldreg #(.N(RW)) u_yreg   (.clk(clk), .rst(rst), .ld(ctl.ld_y),   .d(sum),  .q(y));

  // First multiplier operand: captured x or stored square
  always_comb begin
    if (ctl.ma == MA_XX) mul_a = xx_q;
    else                 mul_a = {{PAD{1'b0}}, x_q};
  end

  // Second multiplier operand: x, A or B
  always_comb begin
    unique case (ctl.mb)
      MB_A:    mul_b = {{PAD{1'b0}}, a_in};
      MB_B:    mul_b = {{PAD{1'b0}}, b_in};
      default: mul_b = {{PAD{1'b0}}, x_q};
    endcase
  end

  // Second adder operand: C or stored partial sum
  always_comb begin
    if (ctl.ab == AB_BXC) add_b = bxc_q;
    else                  add_b = {{PAD{1'b0}}, c_in};
  end

  assign prod = mul_a * mul_b;
  assign sum  = prod + add_b;
endmodule

// File: rtl/quad_fsmd.sv
module quad_fsmd
  import quad_fsmd_pkg::*;
#(
  parameter int W  = 8,
  parameter int RW = 3 * W + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [W-1:0]  x_in,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [W-1:0]  c_in,
  output logic [RW-1:0] y_out,
  output logic          done,
  output logic          ready
);
  ctrl_t ctl;
  logic  idle;

  quad_ctrl u_ctrl (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .ctl (ctl),
    .idle(idle)
  );

  quad_dpath #(.W(W), .RW(RW)) u_dpath (
    .clk (clk),
    .rst (rst),
    .ctl (ctl),
    .x_in(x_in),
    .a_in(a_in),
    .b_in(b_in),
    .c_in(c_in),
    .y   (y_out)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= ctl.ld_y;
  end

  assign ready = idle;
endmodule

// File: rtl/quad_fsmd_chk.sv
module quad_fsmd_chk #(
  parameter int RW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          ready,
  input logic          done,
  input logic [RW-1:0] y_out
);
  // cycles since acceptance: 1..5, 0 when no request is running
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)                 age <= 3'd0;
    else if (ready && go)    age <= 3'd1;
    else if (age == 3'd5)    age <= 3'd0;
    else if (age != 3'd0)    age <= age + 3'd1;
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (age == 3'd5));

  assert_done_expected_R5: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd4) |=> done);

  assert_busy_window_R4: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && age <= 3'd4) |-> !ready);

  assert_ready_at_done_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);

  assert_y_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(y_out));
endmodule

bind quad_fsmd quad_fsmd_chk #(.RW(RW)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .go   (go),
  .ready(ready),
  .done (done),
  .y_out(y_out)
);

// File: tb/tb_quad_fsmd.sv
module tb_quad_fsmd;
  localparam int W  = 8;
  localparam int RW = 3 * W + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          go  = 1'b0;
  logic [W-1:0]  x_in = '0, a_in = '0, b_in = '0, c_in = '0;
  logic [RW-1:0] y_out;
  logic          done, ready;

  int checks = 0;
  int bad    = 0;
  longint unsigned expq[$];
  int cyc = 0;

  quad_fsmd #(.W(W), .RW(RW)) dut (
    .clk(clk), .rst(rst), .go(go),
    .x_in(x_in), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .y_out(y_out), .done(done), .ready(ready)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned model(input longint unsigned xv, av, bv, cv);
    longint unsigned r;
    r = av * xv * xv + bv * xv + cv;
    return r & ((64'd1 << RW) - 1);
  endfunction

  // Monitor: compares every result against the scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected result", y_out, 0);
      end else begin
        longint unsigned e;
        e = expq.pop_front();
        check(y_out == RW'(e), "R2 result value", y_out, e);
      end
    end
  end

  // Driver: one request with optional x change and busy-time go
  task automatic run_req(input logic [W-1:0] xv, av, bv, cv,
                         input bit wiggle_x, input bit busy_go);
    longint unsigned e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    x_in = xv; a_in = av; b_in = bv; c_in = cv; go = 1'b1;
    e = model(xv, av, bv, cv);
    expq.push_back(e);
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      go = 1'b0;
      check(ready == 1'b0, "R4 ready low while busy", ready, 0);
      check(done == 1'b0, "R3 no early done", done, 0);
      if (wiggle_x) x_in = ~xv;                 // R6
      if (busy_go) go = (n < 4);                // R5
    end
    go = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R3 done on fourth edge after start", done, 1);
    check(ready == 1'b1, "R4 ready with done", ready, 1);
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle wide", done, 0);
    check(y_out == RW'(e), "R7 y held after done", y_out, e);
    if (busy_go) begin
      for (int n = 0; n < 4; n++) begin
        @(negedge clk);
        check(done == 1'b0, "R5 busy go caused no second run", done, 0);
        check(ready == 1'b1, "R5 still idle", ready, 1);
      end
    end
  endtask

  // Back-to-back requests with go held high
  task automatic run_b2b();
    @(negedge clk);
    while (!ready) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      logic [W-1:0] xv, av, bv, cv;
      xv = W'(20 + 7 * k); av = W'(3 + k); bv = W'(100 - k); cv = W'(50 * k + 1);
      x_in = xv; a_in = av; b_in = bv; c_in = cv; go = 1'b1;
      expq.push_back(model(xv, av, bv, cv));
      for (int n = 1; n <= 4; n++) begin
        @(negedge clk);
        check(done == 1'b0, "R8 no done inside period", done, 0);
      end
      @(negedge clk);
      check(done == 1'b1, "R8 result every five cycles", done, 1);
    end
    go = 1'b0;
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(y_out == '0, "R1 y reset", y_out, 0);
    check(done == 1'b0, "R1 done reset", done, 0);
    check(ready == 1'b1, "R1 ready reset", ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(y_out == '0, "R1 y after reset release", y_out, 0);

    run_req(8'd3,   8'd2,   8'd5,   8'd7,   1'b0, 1'b0); // R2 mixed: 40
    run_req(8'd0,   8'd0,   8'd0,   8'd0,   1'b0, 1'b0); // R2 zeros
    run_req(8'd255, 8'd255, 8'd255, 8'd255, 1'b0, 1'b0); // R2 max
    run_req(8'd10,  8'd1,   8'd0,   8'd0,   1'b0, 1'b0); // R2 A only: 100
    run_req(8'd1,   8'd0,   8'd0,   8'd9,   1'b0, 1'b0); // R2 C only: 9
    run_req(8'd12,  8'd0,   8'd11,  8'd0,   1'b0, 1'b0); // R2 B only: 132
    run_req(8'd6,   8'd4,   8'd3,   8'd2,   1'b1, 1'b0); // R6 x wiggled
    run_req(8'd9,   8'd7,   8'd8,   8'd1,   1'b0, 1'b1); // R5 go while busy
    run_b2b();                                          // R8

    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R2 all results delivered", expq.size(), 0);
    finish_up();
  end
endmodule